// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of a memory operand in a 16-bit segmented machine. On each accepted request it picks register and displacement terms according to an addressing mode and adds them into a 16-bit offset. It then places that offset inside a segment: the segment value is shifted left by four bits and the offset is added, which gives a 20-bit physical address. Both results come out of registers one clock after the request.

The request carries the mode, the selectors for the base, index and single-register operands, a displacement of either short or full width, and the segment value to use. The values of the four pointer registers arrive on their own inputs. Decoding instructions and running the bus belong to the surrounding core, not to this block.

The block also holds the start-up code location. Reset loads a code segment and an instruction pointer whose combined physical address is the first fetch location. That pair stays fixed until the next reset.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is active, and after it is released until the first accepted request, `out_valid` is 0 and `out_offset` and `out_phys` are 0. `code_seg` reads F000h, `instr_ptr` reads FFF0h and `fetch_phys` reads FFFF0h.
- R2: A request is accepted at a rising edge when `req_valid` is 1 and `req_mode` is 0 to 5. `out_valid` is 1 during the cycle after that edge only. Requests on consecutive cycles each give their own result one cycle later.
- R3: Mode encoding is: 0 direct, 1 register indirect, 2 based, 3 indexed, 4 based-indexed, 5 based-indexed with displacement. In direct mode the offset is the extended displacement.
- R4: In register-indirect mode the offset is one register, picked by `req_ind_sel`: 0 SI, 1 DI, 2 BX, 3 BP.
- R5: Based mode adds the extended displacement to BX (`req_base_sel`=0) or BP (`req_base_sel`=1). Indexed mode adds it to SI (`req_idx_sel`=0) or DI (`req_idx_sel`=1).
- R6: Mode 4 gives base plus index. Mode 5 gives base plus index plus extended displacement. Both use the selectors of R5.
- R7: When `req_disp_wide` is 0, `req_disp[7:0]` is sign-extended to 16 bits and `req_disp[15:8]` has no effect. When `req_disp_wide` is 1, all 16 bits are used.
- R8: The offset sum is taken modulo 2^16.
- R9: `out_phys` equals (`req_seg` × 16 + offset) modulo 2^20, where `req_seg` is the value captured with the request.
- R10: When no request is accepted at an edge, `out_offset` and `out_phys` keep their values.
- R11: A request with `req_mode` 6 or 7 is dropped. `out_valid` stays 0 and both results are unchanged.
- R12: `code_seg` and `instr_ptr` keep their reset values for as long as reset stays released, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_base_sel | input | 1 | Base register select: 0 BX, 1 BP |
| req_idx_sel | input | 1 | Index register select: 0 SI, 1 DI |
| req_ind_sel | input | 2 | Register-indirect select: 0 SI, 1 DI, 2 BX, 3 BP |
| req_disp_wide | input | 1 | 1 selects the full 16-bit displacement, 0 the short 8-bit one |
| req_disp | input | 16 | Displacement or direct address |
| req_seg | input | 16 | Segment value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |
| code_seg | output | 16 | Code segment after reset |
| instr_ptr | output | 16 | Instruction pointer after reset |
| fetch_phys | output | 20 | First fetch physical address |

## Verification
Some behaviour is checked by assertions on every cycle: the one-cycle timing of the valid flag, the dropping of the reserved mode codes, the holding of the results between requests, the link between the physical address and the captured segment and offset, the based-indexed sum, and the constant code location. Other behaviour can only be shown by the bench's scenarios. This covers each register-select encoding, sign extension of short displacements that have the upper byte set, wrap-around of the offset and of the physical address, and the clearing of the results by a reset in mid-operation. The bench compares these against a table of hand-derived values and against its own reference model.

// File: rtl/seg_addr_pkg.sv
`timescale 1ns/1ps
package seg_addr_pkg;
  parameter int OFS_W     = 16;
  parameter int SHORT_W   = 8;
  parameter int SEG_SHIFT = 4;
  parameter int PA_W      = OFS_W + SEG_SHIFT;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_REG_IND  = 3'd1,
    AM_BASED    = 3'd2,
    AM_INDEXED  = 3'd3,
    AM_BASE_IDX = 3'd4,
    AM_BIDX_DSP = 3'd5
  } amode_e;

  localparam logic [2:0] AM_LAST = 3'd5;

  typedef struct packed {
    logic [OFS_W-1:0] term_a;
    logic [OFS_W-1:0] term_b;
    logic [OFS_W-1:0] term_c;
  } terms_t;
endpackage

// File: rtl/sag_disp_ext.sv
`timescale 1ns/1ps
module sag_disp_ext #(
  parameter int OFS_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic [OFS_W-1:0] disp_in,
  input  logic             wide,
  output logic [OFS_W-1:0] disp_out
);
  localparam int EXT_W = OFS_W - SHORT_W;

  logic [OFS_W-1:0] short_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign short_ext = {{EXT_W{disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};
    end else begin : g_noext
      assign short_ext = disp_in;
    end
  endgenerate

  assign disp_out = wide ? disp_in : short_ext;
endmodule

// File: rtl/sag_operand_sel.sv
`timescale 1ns/1ps
module sag_operand_sel
  import seg_addr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode,
  input  logic         base_sel,
  input  logic         idx_sel,
  input  logic [1:0]   ind_sel,
  input  logic [W-1:0] disp_ext,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] bp,
  input  logic [W-1:0] si,
  input  logic [W-1:0] di,
  output logic [W-1:0] term_a,
  output logic [W-1:0] term_b,
  output logic [W-1:0] term_c,
  output logic         legal
);
  logic [W-1:0] base_v;
  logic [W-1:0] idx_v;
  logic [W-1:0] ind_v;

  always_comb begin
    base_v = base_sel ? bp : bx;
    idx_v  = idx_sel  ? di : si;
    unique case (ind_sel)
      2'd0:    ind_v = si;
      2'd1:    ind_v = di;
      2'd2:    ind_v = bx;
      default: ind_v = bp;
    endcase
  end

  always_comb begin
    term_a = '0;
    term_b = '0;
    term_c = '0;
    legal  = 1'b1;
    case (mode)
      AM_DIRECT:   term_c = disp_ext;
      AM_REG_IND:  term_a = ind_v;
      AM_BASED: begin
        term_a = base_v;
        term_c = disp_ext;
      end
      AM_INDEXED: begin
        term_b = idx_v;
        term_c = disp_ext;
      end
      AM_BASE_IDX: begin
        term_a = base_v;
        term_b = idx_v;
      end
      AM_BIDX_DSP: begin
        term_a = base_v;
        term_b = idx_v;
        term_c = disp_ext;
      end
      default:     legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/sag_phys_map.sv
`timescale 1ns/1ps
module sag_phys_map #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [OFS_W-1:0]           seg,
  input  logic [OFS_W-1:0]           ofs,
  output logic [OFS_W+SEG_SHIFT-1:0] phys
);
  localparam int PW = OFS_W + SEG_SHIFT;

  logic [PW-1:0] seg_sh;
  logic [PW-1:0] ofs_z;

  assign seg_sh = {seg, {SEG_SHIFT{1'b0}}};
  assign ofs_z  = {{SEG_SHIFT{1'b0}}, ofs};
  assign phys   = seg_sh + ofs_z;
endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter logic [OFS_W-1:0] CS_RESET = 16'hF000,
  parameter logic [OFS_W-1:0] IP_RESET = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic             req_base_sel,
  input  logic             req_idx_sel,
  input  logic [1:0]       req_ind_sel,
  input  logic             req_disp_wide,
  input  logic [OFS_W-1:0] req_disp,
  input  logic [OFS_W-1:0] req_seg,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  output logic             out_valid,
  output logic [OFS_W-1:0] out_offset,
  output logic [PA_W-1:0]  out_phys,
  output logic [OFS_W-1:0] code_seg,
  output logic [OFS_W-1:0] instr_ptr,
  output logic [PA_W-1:0]  fetch_phys
);
  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [OFS_W-1:0] disp_x;
  terms_t           terms;
  logic             mode_legal;
  logic [OFS_W-1:0] ofs_c;
  logic [PA_W-1:0]  phys_c;

  sag_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ext (
    .disp_in (req_disp),
    .wide    (req_disp_wide),
    .disp_out(disp_x)
  );

  sag_operand_sel #(.W(OFS_W)) u_sel (
    .mode    (req_mode),
    .base_sel(req_base_sel),
    .idx_sel (req_idx_sel),
    .ind_sel (req_ind_sel),
    .disp_ext(disp_x),
    .bx      (reg_bx),
    .bp      (reg_bp),
    .si      (reg_si),
    .di      (reg_di),
    .term_a  (terms.term_a),
    .term_b  (terms.term_b),
    .term_c  (terms.term_c),
    .legal   (mode_legal)
  );

  // three-term sum truncated to the offset width
  assign ofs_c = terms.term_a + terms.term_b + terms.term_c;

  sag_phys_map #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_map (
    .seg (req_seg),
    .ofs (ofs_c),
    .phys(phys_c)
  );

  sag_phys_map #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_fetch (
    .seg (code_seg),
    .ofs (instr_ptr),
    .phys(fetch_phys)
  );

  // next-state logic
  logic             accept;
  logic             valid_d;
  logic [OFS_W-1:0] ofs_d;
  logic [PA_W-1:0]  phys_d;

  always_comb begin
    accept  = req_valid & mode_legal;
    valid_d = accept;
    ofs_d   = out_offset;
    phys_d  = out_phys;
    if (accept) begin
      ofs_d  = ofs_c;
      phys_d = phys_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_phys   <= '0;
    end else begin
      out_valid  <= valid_d;
      out_offset <= ofs_d;
      out_phys   <= phys_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_seg  <= CS_RESET;
      instr_ptr <= IP_RESET;
    end else begin
      code_seg  <= code_seg;
      instr_ptr <= instr_ptr;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
`timescale 1ns/1ps
module seg_addr_gen_chk
  import seg_addr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_mode,
  input logic             req_base_sel,
  input logic             req_idx_sel,
  input logic [OFS_W-1:0] req_seg,
  input logic [OFS_W-1:0] reg_bx,
  input logic [OFS_W-1:0] reg_bp,
  input logic [OFS_W-1:0] reg_si,
  input logic [OFS_W-1:0] reg_di,
  input logic             out_valid,
  input logic [OFS_W-1:0] out_offset,
  input logic [PA_W-1:0]  out_phys,
  input logic [OFS_W-1:0] code_seg,
  input logic [OFS_W-1:0] instr_ptr
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic [OFS_W-1:0] base_pick;
  logic [OFS_W-1:0] idx_pick;
  logic [PA_W-1:0]  seg_sh;

  assign base_pick = req_base_sel ? reg_bp : reg_bx;
  assign idx_pick  = req_idx_sel  ? reg_di : reg_si;
  assign seg_sh    = {req_seg, {SEG_SHIFT{1'b0}}};

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    out_valid == $past(req_valid && (req_mode <= AM_LAST)));

  // R11
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(req_valid) && $past(req_mode) > AM_LAST) |-> !out_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !out_valid |-> ($stable(out_offset) && $stable(out_phys)));

  // R9
  phys_map_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    out_valid |-> (out_phys == PA_W'($past(seg_sh) + {{SEG_SHIFT{1'b0}}, out_offset})));

  // R6
  base_idx_sum_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (out_valid && $past(req_mode) == AM_BASE_IDX)
      |-> (out_offset == OFS_W'($past(base_pick) + $past(idx_pick))));

  // R12
  start_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_seg == 16'hF000) && (instr_ptr == 16'hFFF0));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .req_base_sel(req_base_sel),
  .req_idx_sel (req_idx_sel),
  .req_seg     (req_seg),
  .reg_bx      (reg_bx),
  .reg_bp      (reg_bp),
  .reg_si      (reg_si),
  .reg_di      (reg_di),
  .out_valid   (out_valid),
  .out_offset  (out_offset),
  .out_phys    (out_phys),
  .code_seg    (code_seg),
  .instr_ptr   (instr_ptr)
);

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_mode;
  logic        req_base_sel;
  logic        req_idx_sel;
  logic [1:0]  req_ind_sel;
  logic        req_disp_wide;
  logic [15:0] req_disp;
  logic [15:0] req_seg;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di;
  logic        out_valid;
  logic [15:0] out_offset;
  logic [19:0] out_phys;
  logic [15:0] code_seg;
  logic [15:0] instr_ptr;
  logic [19:0] fetch_phys;

  int vectors;
  int miscompares;

  seg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_base_sel(req_base_sel), .req_idx_sel(req_idx_sel), .req_ind_sel(req_ind_sel),
    .req_disp_wide(req_disp_wide), .req_disp(req_disp), .req_seg(req_seg),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .out_valid(out_valid), .out_offset(out_offset), .out_phys(out_phys),
    .code_seg(code_seg), .instr_ptr(instr_ptr), .fetch_phys(fetch_phys)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  mode;
    logic        bsel;
    logic        isel;
    logic [1:0]  rsel;
    logic        wide;
    logic [15:0] disp;
    logic [15:0] seg;
    logic [15:0] exp_ofs;
    logic [19:0] exp_phys;
  } vec_t;

  // registers fixed for the table: BX=1234 BP=0F00 SI=0010 DI=8000
  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b1, 16'hABCD, 16'h1000, 16'hABCD, 20'h1ABCD}, // R3 direct wide
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h00F0, 16'h0000, 16'hFFF0, 20'h0FFF0}, // R7 short negative
    '{3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0000, 16'h2000, 16'h0010, 20'h20010}, // R4 SI
    '{3'd1, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0000, 16'h2000, 16'h8000, 20'h28000}, // R4 DI
    '{3'd1, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0000, 16'h0001, 16'h1234, 20'h01244}, // R4 BX
    '{3'd1, 1'b0, 1'b0, 2'd3, 1'b0, 16'h0000, 16'h0001, 16'h0F00, 20'h00F10}, // R4 BP
    '{3'd2, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0080, 16'h0000, 16'h11B4, 20'h011B4}, // R5 BX short neg
    '{3'd2, 1'b1, 1'b0, 2'd0, 1'b1, 16'h0100, 16'hF000, 16'h1000, 20'hF1000}, // R5 BP
    '{3'd3, 1'b0, 1'b1, 2'd0, 1'b1, 16'h8000, 16'h0000, 16'h0000, 20'h00000}, // R8 DI wrap
    '{3'd3, 1'b0, 1'b0, 2'd0, 1'b0, 16'h007F, 16'h0100, 16'h008F, 20'h0108F}, // R5 SI short pos
    '{3'd4, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0000, 16'hFFFF, 16'h1244, 20'h01234}, // R9 wrap
    '{3'd4, 1'b1, 1'b1, 2'd0, 1'b0, 16'h0000, 16'h0A00, 16'h8F00, 20'h12F00}, // R6 BP+DI
    '{3'd5, 1'b0, 1'b1, 2'd0, 1'b0, 16'h00FE, 16'h0000, 16'h9232, 20'h09232}, // R6 BX+DI+d8
    '{3'd5, 1'b1, 1'b0, 2'd0, 1'b1, 16'h7000, 16'hF800, 16'h7F10, 20'hFFF10}, // R6 BP+SI+d16
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1205, 16'h0000, 16'h0005, 20'h00005}  // R7 upper ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_ofs(input logic [2:0] m, input logic bs, input logic is,
                                          input logic [1:0] rs, input logic wd, input logic [15:0] d,
                                          input logic [15:0] bx, input logic [15:0] bp,
                                          input logic [15:0] si, input logic [15:0] di);
    logic [15:0] dx, b, x, r;
    dx = wd ? d : {{8{d[7]}}, d[7:0]};
    b  = bs ? bp : bx;
    x  = is ? di : si;
    r  = (rs == 2'd0) ? si : (rs == 2'd1) ? di : (rs == 2'd2) ? bx : bp;
    case (m)
      3'd0:    return dx;
      3'd1:    return r;
      3'd2:    return b + dx;
      3'd3:    return x + dx;
      3'd4:    return b + x;
      default: return b + x + dx;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [2:0] m, input logic bs, input logic is,
                       input logic [1:0] rs, input logic wd, input logic [15:0] d, input logic [15:0] s);
    req_valid = v; req_mode = m; req_base_sel = bs; req_idx_sel = is;
    req_ind_sel = rs; req_disp_wide = wd; req_disp = d; req_seg = s;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vectors = 0;
    miscompares = 0;
    reg_bx = 16'h1234; reg_bp = 16'h0F00; reg_si = 16'h0010; reg_di = 16'h8000;
    drive(1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 code_seg", 32'(code_seg), 32'h0000F000);
    chk("R1 instr_ptr", 32'(instr_ptr), 32'h0000FFF0);
    chk("R1 fetch_phys", 32'(fetch_phys), 32'h000FFFF0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 offset after release", 32'(out_offset), 32'd0);
    chk("R1 phys after release", 32'(out_phys), 32'd0);
    chk("R1 valid after release", 32'(out_valid), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VT[i].mode, VT[i].bsel, VT[i].isel, VT[i].rsel, VT[i].wide, VT[i].disp, VT[i].seg);
      @(negedge clk);
      chk("R2 valid after strobe", 32'(out_valid), 32'd1);
      chk("R3-table offset", 32'(out_offset), 32'(VT[i].exp_ofs));
      chk("R9 table phys", 32'(out_phys), 32'(VT[i].exp_phys));
      drive(1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0);
      @(negedge clk);
      chk("R2 valid single cycle", 32'(out_valid), 32'd0);
    end

    // R10 hold: inputs change without a strobe
    drive(1'b0, 3'd5, 1'b1, 1'b1, 2'd3, 1'b1, 16'h5555, 16'h3333);
    repeat (2) @(negedge clk);
    chk("R10 offset held", 32'(out_offset), 32'h00000005);
    chk("R10 phys held", 32'(out_phys), 32'h00000005);

    // R11 reserved codes dropped
    drive(1'b1, 3'd6, 1'b0, 1'b0, 2'd0, 1'b1, 16'h4444, 16'h1111);
    @(negedge clk);
    chk("R11 mode6 valid", 32'(out_valid), 32'd0);
    chk("R11 mode6 offset", 32'(out_offset), 32'h00000005);
    drive(1'b1, 3'd7, 1'b0, 1'b0, 2'd0, 1'b1, 16'h4444, 16'h1111);
    @(negedge clk);
    chk("R11 mode7 valid", 32'(out_valid), 32'd0);
    chk("R11 mode7 phys", 32'(out_phys), 32'h00000005);

    // R2 back-to-back
    drive(1'b1, 3'd1, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0, 16'h0000);
    @(negedge clk);
    chk("R2 b2b first valid", 32'(out_valid), 32'd1);
    chk("R2 b2b first offset", 32'(out_offset), 32'h00001234);
    drive(1'b1, 3'd1, 1'b0, 1'b0, 2'd3, 1'b0, 16'h0, 16'h0000);
    @(negedge clk);
    chk("R2 b2b second valid", 32'(out_valid), 32'd1);
    chk("R2 b2b second offset", 32'(out_offset), 32'h00000F00);
    drive(1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0);
    @(negedge clk);

    // R8 / R6 model sweep with varied registers
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d, s;
      logic [2:0]  m;
      logic [15:0] e;
      reg_bx = 16'(16'h9E37 * (k + 1));
      reg_bp = 16'(16'h7F4A ^ (k * 16'h0321));
      reg_si = 16'(16'hC001 + k * 16'h1111);
      reg_di = 16'(16'hFFFF - k * 16'h0707);
      d = 16'(16'hF00D * (k + 3));
      s = 16'(16'hFEDC + k * 16'h0135);
      m = 3'(k % 6);
      e = ref_ofs(m, k[0], k[1], k[3:2], k[2], d, reg_bx, reg_bp, reg_si, reg_di);
      drive(1'b1, m, k[0], k[1], k[3:2], k[2], d, s);
      @(negedge clk);
      chk("R8 model offset", 32'(out_offset), 32'(e));
      chk("R9 model phys", 32'(out_phys), 32'(20'({s, 4'h0} + {4'h0, e})));
    end
    drive(1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0);
    @(negedge clk);

    // R12 code location unchanged after activity
    chk("R12 code_seg", 32'(code_seg), 32'h0000F000);
    chk("R12 instr_ptr", 32'(instr_ptr), 32'h0000FFF0);

    // R1 reset in mid-operation clears results
    drive(1'b1, 3'd0, 1'b0, 1'b0, 2'd0, 1'b1, 16'hBEEF, 16'h1234);
    @(negedge clk);
    drive(1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0);
    do_reset();
    chk("R1 offset cleared", 32'(out_offset), 32'd0);
    chk("R1 phys cleared", 32'(out_phys), 32'd0);
    chk("R1 fetch_phys again", 32'(fetch_phys), 32'h000FFFF0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule